// File: doc/BRIEF.md
# Framed Host Command Parser

This block turns a byte stream from a host into configuration register writes and reply frames. Each command frame opens with the byte 0x99. The next byte is an identifier, followed by a payload whose length that identifier fixes, and the frame closes with 0x66. The parser holds a bank of 35 writable parameter bytes and drives the most-used fields straight out as configuration signals. It answers a list-read command with a dump frame. A soft-reset command loads the defaults, and a malformed frame produces an error frame.

Reception runs through six named states. In `S_IDLE` the parser waits for a header. In `S_ID` it decodes the identifier. `S_PAYLOAD` collects payload bytes into a shadow buffer, and `S_END` expects the trailer. `S_REPLY` waits while a reply frame is sent. `S_DROP` discards bytes after a fault.

The transitions are as follows. IDLE goes to ID on 0x99. ID goes to PAYLOAD when the identifier has a payload, and to END when it has none. PAYLOAD goes to END after the last payload byte. END goes to IDLE after a write or a soft reset, and to REPLY after a list read. Any fault goes to REPLY. REPLY goes to IDLE or to DROP once the reply is accepted. DROP goes to ID on 0x99.

The transmitter has two states. `T_IDLE` goes to `T_SEND` on a start request, and `T_SEND` goes back to `T_IDLE` when the trailer is accepted.

Top module: `cmd_frame_parser`

## Requirements
- R1: A byte other than 0x99 arriving in the idle state produces the reply 0x99 0x88 0x99 0x66.
- R2: An identifier outside {0x10..0x1F, 0x20..0x23, 0x30..0x33, 0x35, 0x50, 0x55, 0xFF} produces the reply 0x99 0x88 0x89 0x66.
- R3: A byte other than 0x66 in the trailer position produces the reply 0x99 0x88 0x66 0x66, and the frame's payload is not applied.
- R4: After any error reply, every byte is discarded until the next 0x99, which is taken as a new header.
- R5: Single-parameter writes are applied only after a correct trailer, with these lengths and bank positions: 0x10..0x1F take 1 byte at index id-0x10; 0x20..0x23 take 2 bytes at index 16+2·(id-0x20); 0x30 takes 1 byte at index 24; 0x31..0x33 take 2 bytes at index 25+2·(id-0x31); 0x35 takes 4 bytes at index 31. Multi-byte values arrive most significant byte first, and the first byte lands at the lowest index.
- R6: Identifier 0x50 carries 35 bytes that replace bank indices 0..34 in order.
- R7: Identifier 0x55 (no payload) produces a 79-byte reply: 0x99, 0x55, 76 data bytes, 0x66. Data byte j is bank[j] for j<31, 0x00 for j=31, bank[j-1] for j=32..35, and 0x00 for j≥36.
- R8: Identifier 0xFF (no payload) restores every bank byte to its default and sends no reply.
- R9: After reset the bank holds its defaults: 0x80 at 0..7, 0x00 at 8..9, 0xFF at 10..11, 0x58 at 12, 0xE6 at 13, 0x00 at 14..15, 01 00 08 00 01 00 08 00 at 16..23, 0x08 at 24, 00 C8 01 90 01 90 at 25..30, and 0x00 at 31..34. tx_valid is low.
- R10: cfg_trig_cond equals bank[24]. cfg_data_en equals bit 0 of bank[34], and cfg_sec_en equals bit 1 of bank[34].
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R12: Bytes that arrive while a reply frame is being sent are discarded and change no parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| tx_ready | input | 1 | Sink accepts the reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| cfg_trig_cond | output | 8 | Trigger-condition parameter |
| cfg_data_en | output | 1 | Data output enable |
| cfg_sec_en | output | 1 | Once-per-second message enable |

## Verification
Several rules are checked by assertions on every cycle. The reply stays stable under backpressure, and every reply begins with the header byte. A commit or a defaults load is always followed by the expected bank contents. Only one action fires at a time, and no reply starts while another is in flight. Other behaviour can only be shown by the bench's scenarios, which compare every reply byte against a bench-side model of the bank. These cover the exact error codes, the byte placement of each write, the skipped status position in the dump, the discarding of bytes after a fault or during a reply, and the restoration of defaults.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    localparam int          BANK_BYTES = 35;
    localparam int          DUMP_BYTES = 76;
    localparam int          IW         = $clog2(BANK_BYTES + 1);
    localparam logic [7:0]  HDR        = 8'h99;
    localparam logic [7:0]  TRL        = 8'h66;
    localparam logic [7:0]  ID_DUMP    = 8'h55;
    localparam logic [7:0]  ID_ERR     = 8'h88;
    localparam logic [7:0]  ERR_HDR    = 8'h99;
    localparam logic [7:0]  ERR_ID     = 8'h89;
    localparam logic [7:0]  ERR_END    = 8'h66;

    typedef logic [BANK_BYTES-1:0][7:0] bank_t;
    typedef enum logic [1:0] {ACT_WRITE, ACT_DUMP, ACT_DEF} act_e;
    typedef struct packed {
        logic          known;
        logic [IW-1:0] base;
        logic [IW-1:0] len;
        act_e          act;
    } idinfo_t;

    function automatic logic [7:0] default_byte(input int idx);
        case (idx)
            0, 1, 2, 3, 4, 5, 6, 7: return 8'h80;
            10, 11:                 return 8'hFF;
            12:                     return 8'h58;
            13:                     return 8'hE6;
            16, 20:                 return 8'h01;
            18, 22:                 return 8'h08;
            24:                     return 8'h08;
            26:                     return 8'hC8;
            27, 29:                 return 8'h01;
            28, 30:                 return 8'h90;
            default:                return 8'h00;
        endcase
    endfunction

    function automatic idinfo_t decode_id(input logic [7:0] id);
        idinfo_t r;
        r.known = 1'b1;
        r.act   = ACT_WRITE;
        r.base  = '0;
        r.len   = '0;
        if (id[7:4] == 4'h1) begin
            r.base = IW'(id[3:0]);
            r.len  = IW'(1);
        end else if (id >= 8'h20 && id <= 8'h23) begin
            r.base = IW'(16 + 2 * int'(id[1:0]));
            r.len  = IW'(2);
        end else if (id == 8'h30) begin
            r.base = IW'(24);
            r.len  = IW'(1);
        end else if (id >= 8'h31 && id <= 8'h33) begin
            r.base = IW'(25 + 2 * (int'(id[1:0]) - 1));
            r.len  = IW'(2);
        end else if (id == 8'h35) begin
            r.base = IW'(31);
            r.len  = IW'(4);
        end else if (id == 8'h50) begin
            r.len  = IW'(BANK_BYTES);
        end else if (id == ID_DUMP) begin
            r.act  = ACT_DUMP;
        end else if (id == 8'hFF) begin
            r.act  = ACT_DEF;
        end else begin
            r.known = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/cmd_param_bank.sv
module cmd_param_bank
    import cmd_pkg::*;
#(
    parameter int NBYTES = BANK_BYTES,
    parameter int RDW    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_commit,
    input  logic [IW-1:0]      wr_base,
    input  logic [IW-1:0]      wr_len,
    input  bank_t              shadow,
    input  logic               load_def,
    input  logic [RDW-1:0]     rd_idx,
    output logic [7:0]         rd_byte,
    output logic [7:0]         cfg_trig_cond,
    output logic               cfg_data_en,
    output logic               cfg_sec_en
);
    localparam int STATUS_POS = 31;
    localparam int TRIG_POS   = 24;
    localparam int SPARE_LSB  = NBYTES - 1;

    bank_t store;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        logic in_range;
        assign in_range = (k >= int'(wr_base)) && (k < int'(wr_base) + int'(wr_len));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    store[k] <= default_byte(k);
            else if (load_def)             store[k] <= default_byte(k);
            else if (wr_commit && in_range) store[k] <= shadow[k];
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (int'(rd_idx) < STATUS_POS)
            rd_byte = store[rd_idx[IW-1:0]];
        else if (int'(rd_idx) > STATUS_POS && int'(rd_idx) <= NBYTES)
            rd_byte = store[rd_idx[IW-1:0] - IW'(1)];
    end

    assign cfg_trig_cond = store[TRIG_POS];
    assign cfg_data_en   = store[SPARE_LSB][0];
    assign cfg_sec_en    = store[SPARE_LSB][1];

    p_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_def |=> (cfg_trig_cond == 8'h08 && !cfg_data_en && !cfg_sec_en));
    p_commit_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !load_def && wr_base == IW'(TRIG_POS) && wr_len == IW'(1))
        |=> cfg_trig_cond == $past(shadow[TRIG_POS]));
endmodule

// File: rtl/cmd_reply_tx.sv
module cmd_reply_tx
    import cmd_pkg::*;
#(
    parameter int NDUMP = DUMP_BYTES,
    parameter int RDW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_err,
    input  logic [7:0]      code,
    input  logic [7:0]      rd_byte,
    output logic [RDW-1:0]  rd_idx,
    input  logic            tx_ready,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    output logic            busy,
    output logic            done
);
    localparam int FRAME_DUMP = NDUMP + 3;
    localparam int FRAME_ERR  = 4;
    localparam int PW         = $clog2(FRAME_DUMP);

    typedef enum logic {T_IDLE, T_SEND} tstate_e;
    tstate_e       tstate;
    logic [PW-1:0] pos;
    logic          err_q;
    logic [7:0]    code_q;
    logic [PW-1:0] last;

    assign last     = err_q ? PW'(FRAME_ERR - 1) : PW'(FRAME_DUMP - 1);
    assign tx_valid = (tstate == T_SEND);
    assign busy     = tx_valid;
    assign done     = tx_valid && tx_ready && (pos == last);
    assign rd_idx   = RDW'(pos - PW'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tstate <= T_IDLE;
            pos    <= '0;
            err_q  <= 1'b0;
            code_q <= 8'h00;
        end else begin
            unique case (tstate)
                T_IDLE: if (start) begin
                    tstate <= T_SEND;
                    pos    <= '0;
                    err_q  <= is_err;
                    code_q <= code;
                end
                T_SEND: if (tx_ready) begin
                    if (pos == last) tstate <= T_IDLE;
                    pos <= pos + PW'(1);
                end
                default: tstate <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        if (pos == '0)          tx_data = HDR;
        else if (pos == PW'(1)) tx_data = err_q ? ID_ERR : ID_DUMP;
        else if (pos == last)   tx_data = TRL;
        else                    tx_data = err_q ? code_q : rd_byte;
    end

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    p_first_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == HDR);
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
    import cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_busy,
    input  logic          tx_done,
    output bank_t         shadow,
    output logic          wr_commit,
    output logic [IW-1:0] wr_base,
    output logic [IW-1:0] wr_len,
    output logic          load_def,
    output logic          tx_start,
    output logic          tx_is_err,
    output logic [7:0]    tx_code
);
    typedef enum logic [2:0] {S_IDLE, S_ID, S_PAYLOAD, S_END, S_REPLY, S_DROP} rstate_e;
    rstate_e       state, nxt;
    idinfo_t       info, dec;
    logic [IW-1:0] cnt;
    logic          drop_after;
    logic          fault;
    logic [7:0]    fault_code;

    assign dec     = decode_id(rx_data);
    assign wr_base = info.base;
    assign wr_len  = info.len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        fault      = 1'b0;
        fault_code = ERR_HDR;
        unique case (state)
            S_IDLE: if (rx_valid) begin
                if (rx_data == HDR) nxt = S_ID;
                else begin fault = 1'b1; fault_code = ERR_HDR; end
            end
            S_ID: if (rx_valid) begin
                if (!dec.known) begin fault = 1'b1; fault_code = ERR_ID; end
                else if (dec.len == '0) nxt = S_END;
                else nxt = S_PAYLOAD;
            end
            S_PAYLOAD: if (rx_valid && cnt == info.len - IW'(1)) nxt = S_END;
            S_END: if (rx_valid) begin
                if (rx_data != TRL) begin fault = 1'b1; fault_code = ERR_END; end
                else if (info.act == ACT_DUMP) nxt = S_REPLY;
                else nxt = S_IDLE;
            end
            S_REPLY: if (tx_done) nxt = drop_after ? S_DROP : S_IDLE;
            S_DROP:  if (rx_valid && rx_data == HDR) nxt = S_ID;
            default: nxt = S_IDLE;
        endcase
        if (fault) nxt = S_REPLY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow     <= '0;
            info       <= '0;
            cnt        <= '0;
            drop_after <= 1'b0;
            wr_commit  <= 1'b0;
            load_def   <= 1'b0;
            tx_start   <= 1'b0;
            tx_is_err  <= 1'b0;
            tx_code    <= 8'h00;
        end else begin
            wr_commit <= 1'b0;
            load_def  <= 1'b0;
            tx_start  <= 1'b0;
            if (state == S_ID && rx_valid) begin
                info <= dec;
                cnt  <= '0;
            end
            if (state == S_PAYLOAD && rx_valid) begin
                shadow[info.base + cnt] <= rx_data;
                cnt <= cnt + IW'(1);
            end
            if (state == S_END && rx_valid && rx_data == TRL) begin
                wr_commit <= (info.act == ACT_WRITE);
                load_def  <= (info.act == ACT_DEF);
                if (info.act == ACT_DUMP) begin
                    tx_start   <= 1'b1;
                    tx_is_err  <= 1'b0;
                    drop_after <= 1'b0;
                end
            end
            if (fault) begin
                tx_start   <= 1'b1;
                tx_is_err  <= 1'b1;
                tx_code    <= fault_code;
                drop_after <= 1'b1;
            end
        end
    end

    p_commit_on_trailer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(rx_valid) && $past(rx_data) == TRL));
    p_no_start_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);
    p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, load_def, tx_start}));
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic [7:0] cfg_trig_cond,
    output logic       cfg_data_en,
    output logic       cfg_sec_en
);
    localparam int RDW = $clog2(DUMP_BYTES + 3);

    bank_t          shadow;
    logic           wr_commit, load_def, tx_start, tx_is_err, tx_busy, tx_done;
    logic [IW-1:0]  wr_base, wr_len;
    logic [7:0]     tx_code, rd_byte;
    logic [RDW-1:0] rd_idx;

    cmd_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_busy(tx_busy), .tx_done(tx_done), .shadow(shadow),
        .wr_commit(wr_commit), .wr_base(wr_base), .wr_len(wr_len),
        .load_def(load_def), .tx_start(tx_start), .tx_is_err(tx_is_err),
        .tx_code(tx_code)
    );

    cmd_param_bank #(.NBYTES(BANK_BYTES), .RDW(RDW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_base(wr_base),
        .wr_len(wr_len), .shadow(shadow), .load_def(load_def), .rd_idx(rd_idx),
        .rd_byte(rd_byte), .cfg_trig_cond(cfg_trig_cond),
        .cfg_data_en(cfg_data_en), .cfg_sec_en(cfg_sec_en)
    );

    cmd_reply_tx #(.NDUMP(DUMP_BYTES), .RDW(RDW)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .is_err(tx_is_err),
        .code(tx_code), .rd_byte(rd_byte), .rd_idx(rd_idx), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy), .done(tx_done)
    );
endmodule

// File: tb/test_cmd_frame_parser.sv
module test_cmd_frame_parser;
    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b1;
    logic       tx_valid, cfg_data_en, cfg_sec_en;
    logic [7:0] tx_data, cfg_trig_cond;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    bp_on = 1'b0;
    bit    finished = 1'b0;
    logic [7:0] mdl [35];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    cmd_frame_parser i_cmd_frame_parser (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .cfg_trig_cond(cfg_trig_cond), .cfg_data_en(cfg_data_en),
        .cfg_sec_en(cfg_sec_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void mdl_defaults();
        logic [7:0] d [35] = '{8'h80,8'h80,8'h80,8'h80,8'h80,8'h80,8'h80,8'h80,
                               8'h00,8'h00,8'hFF,8'hFF,8'h58,8'hE6,8'h00,8'h00,
                               8'h01,8'h00,8'h08,8'h00,8'h01,8'h00,8'h08,8'h00,
                               8'h08,8'h00,8'hC8,8'h01,8'h90,8'h01,8'h90,
                               8'h00,8'h00,8'h00,8'h00};
        for (int i = 0; i < 35; i++) mdl[i] = d[i];
    endfunction

    task automatic expect_dump(input string tag);
        exp_q.push_back(8'h99); tag_q.push_back(tag);
        exp_q.push_back(8'h55); tag_q.push_back(tag);
        for (int j = 0; j < 76; j++) begin
            if (j < 31)       exp_q.push_back(mdl[j]);
            else if (j == 31) exp_q.push_back(8'h00);
            else if (j <= 35) exp_q.push_back(mdl[j-1]);
            else              exp_q.push_back(8'h00);
            tag_q.push_back(tag);
        end
        exp_q.push_back(8'h66); tag_q.push_back(tag);
    endtask

    task automatic expect_err(input logic [7:0] code, input string tag);
        bq_t f = '{8'h99, 8'h88, code, 8'h66};
        foreach (f[i]) begin exp_q.push_back(f[i]); tag_q.push_back(tag); end
    endtask

    task automatic send(input bq_t q);
        foreach (q[i]) begin
            rx_valid = 1'b1;
            rx_data  = q[i];
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
    endtask

    task automatic settle(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin @(posedge clk); #1; n++; end
        repeat (12) @(posedge clk);
        #1;
        chk({tag, " reply complete"}, exp_q.size(), 0);
    endtask

    task automatic chk_cfg(input string tag);
        chk({tag, " trig"}, cfg_trig_cond, mdl[24]);
        chk({tag, " data_en"}, cfg_data_en, mdl[34][0]);
        chk({tag, " sec_en"}, cfg_sec_en, mdl[34][1]);
    endtask

    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) chk("R4/R12 unexpected reply byte", tx_data, 32'hFFFF_FFFF);
            else chk(tag_q.pop_front(), tx_data, exp_q.pop_front());
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            tx_ready = bp_on ? (cyc % 5 != 3) : 1'b1;
        end
    end

    initial begin
        while (cyc < 150000 && !finished) @(posedge clk);
        if (!finished) begin
            chk("watchdog", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bq_t pay;
        mdl_defaults();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R9 reset state, R10 outputs
        chk("R9 tx_valid after reset", tx_valid, 0);
        chk_cfg("R9 R10 reset");
        // R7 dump of defaults under backpressure (R11)
        bp_on = 1'b1;
        expect_dump("R7 R9 default dump");
        send('{8'h99, 8'h55, 8'h66});
        settle("R7 R11");
        // R5 single writes
        send('{8'h99, 8'h13, 8'hA5, 8'h66});               mdl[3] = 8'hA5;
        send('{8'h99, 8'h21, 8'h12, 8'h34, 8'h66});        mdl[18] = 8'h12; mdl[19] = 8'h34;
        send('{8'h99, 8'h30, 8'h2C, 8'h66});               mdl[24] = 8'h2C;
        send('{8'h99, 8'h33, 8'hBE, 8'hEF, 8'h66});        mdl[29] = 8'hBE; mdl[30] = 8'hEF;
        send('{8'h99, 8'h35, 8'h00, 8'h00, 8'h00, 8'h03, 8'h66}); mdl[34] = 8'h03;
        repeat (3) @(posedge clk); #1;
        chk_cfg("R5 R10 single writes");
        expect_dump("R5 R7 dump after writes");
        send('{8'h99, 8'h55, 8'h66});
        settle("R5");
        // R2 unknown identifiers
        expect_err(8'h89, "R2 id 0x34");
        send('{8'h99, 8'h34});
        settle("R2");
        expect_err(8'h89, "R2 id 0x47");
        send('{8'h99, 8'h47});
        settle("R2");
        // R3 missing trailer, payload not applied
        expect_err(8'h66, "R3 bad trailer");
        send('{8'h99, 8'h30, 8'h5A, 8'h00});
        settle("R3");
        chk_cfg("R3 payload discarded");
        // R4 bytes dropped until header
        send('{8'h30, 8'h44, 8'h66, 8'h55, 8'h66});
        settle("R4 no reply while dropping");
        chk_cfg("R4 dropped frame");
        send('{8'h99, 8'h30, 8'h61, 8'h66});               mdl[24] = 8'h61;
        repeat (3) @(posedge clk); #1;
        chk_cfg("R4 resync on header");
        // R1 missing header
        bp_on = 1'b0;
        expect_err(8'h99, "R1 missing header");
        send('{8'h12});
        settle("R1");
        // R6 full list write
        pay = '{8'h99, 8'h50};
        for (int i = 0; i < 35; i++) begin
            pay.push_back(8'(i * 7 + 3));
            mdl[i] = 8'(i * 7 + 3);
        end
        pay.push_back(8'h66);
        send('{8'h99});  // header after R1 drop
        send(pay[1:$]);
        repeat (3) @(posedge clk); #1;
        chk_cfg("R6 R10 list write");
        // R12 frame during reply is ignored
        expect_dump("R6 R7 R12 dump after list write");
        send('{8'h99, 8'h55, 8'h66});
        repeat (4) @(posedge clk); #1;
        send('{8'h99, 8'h30, 8'h77, 8'h66});
        settle("R12");
        chk_cfg("R12 write during reply ignored");
        // R8 soft reset
        send('{8'h99, 8'hFF, 8'h66});
        mdl_defaults();
        repeat (3) @(posedge clk); #1;
        chk_cfg("R8 soft reset");
        expect_dump("R8 dump after soft reset");
        send('{8'h99, 8'h55, 8'h66});
        settle("R8");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule